// File: doc/BRIEF.md
# Noise-Shaped Phase-Truncation Sine Oscillator

This block is a numerically controlled oscillator that produces a stream of signed sine amplitude codes for an external digital-to-analog converter. A 16-bit phase register moves forward by a frequency step word on every enabled clock, so the output frequency is the step word times the clock rate divided by 2^16.

Only the top 8 phase bits address the sine table. Dropping the low 8 bits would normally leave a periodic error that shows up as spurs. Here the dropped part is fed back through a fourth-order error-feedback loop, which pushes that error towards high frequencies. Before truncation, the phase gets a correction built from the last four truncation errors. The table holds 256 entries of 12 bits, and it is computed when the design is elaborated.

A parameter can remove the shaping loop. The table address is then simply the top phase bits. A valid flag follows the enable input through the three register stages: phase, shaper and table.

Top module: `dds_nco_core`

## Requirements
- R1: A synchronous active-high reset clears the phase register, the error history, the output code and the valid flag. The output code stays 0 until the first valid sample.
- R2: `valid_o` equals `en_i` delayed by exactly three clock edges.
- R3: On each edge with `en_i` high, the phase register becomes (phase + `fcw_i`) mod 2^16. With `en_i` low, the phase and the error history keep their values, so the sample sequence resumes unchanged once enable returns.
- R4: With shaping on, each enabled sample forms s = (phase + 4·e1 − 6·e2 + 4·e3 − e4) mod 2^16. Here e1..e4 are the previous four truncation errors, e1 being the newest. The table address is s[15:8] and the new error is s[7:0].
- R5: The table entry for address a is round(2047·sin(2πa/256)), given as a 12-bit two's complement code. A valid output is never the code 0x800.
- R6: While `valid_o` is low, `amp_o` keeps its previous value.
- R7: With shaping off (SHAPE_EN = 0), the table address is the top 8 bits of the updated phase register.
- R8: For a constant phase that lies between two table addresses, the mean of the shaped addresses over 256 samples lies within one address step of phase/256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the oscillator by one sample |
| fcw_i | input | 16 | Frequency step word added to the phase |
| amp_o | output | 12 | Signed sine amplitude code |
| valid_o | output | 1 | `amp_o` holds a new sample |

## Verification
A wrong tap or a lost error in the shaping history changes the next table address. The amplitude code then differs from an independent model two edges later, and the error keeps spreading through the following four samples. A phase register that slips or advances while disabled shifts every later sample. A wrong stage count in the valid path shows up as `valid_o` misplaced relative to `en_i` on the first enabled cycle. The average of dithered addresses around a fixed phase reveals a bias in the shaping loop, even where single samples look plausible.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int HIST_DEPTH = 4;

    // Signed sine code for table index k, computed by a series on a reduced angle.
    function automatic int sine_code(int k, int addr_w, int amp_w);
        real pi_v;
        real x;
        real x2;
        real term;
        real s;
        real v;
        pi_v = 3.14159265358979323846;
        x = 2.0 * pi_v * real'(k) / real'(1 << addr_w);
        if (x > pi_v) x = x - 2.0 * pi_v;
        if (x > pi_v / 2.0) x = pi_v - x;
        else if (x < -pi_v / 2.0) x = -pi_v - x;
        x2 = x * x;
        term = x;
        s = x;
        for (int n = 1; n <= 8; n++) begin
            term = -term * x2 / real'((2 * n) * (2 * n + 1));
            s = s + term;
        end
        v = real'((1 << (amp_w - 1)) - 1) * s;
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic [PHASE_W-1:0] fcw_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               step_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_o <= '0;
            step_o  <= 1'b0;
        end else begin
            step_o <= step_i;
            if (step_i) phase_o <= phase_o + fcw_i;
        end
    end

endmodule

// File: rtl/dds_err_shaper.sv
module dds_err_shaper #(
    parameter int PHASE_W  = 16,
    parameter int ADDR_W   = 8,
    parameter bit SHAPE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic [PHASE_W-1:0] phase_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               step_o
);
    import dds_pkg::*;

    localparam int ERR_W = PHASE_W - ADDR_W;
    localparam int PAD_W = PHASE_W - ERR_W;

    always_ff @(posedge clk) begin
        if (rst) step_o <= 1'b0;
        else     step_o <= step_i;
    end

    generate
        if (SHAPE_EN) begin : g_shaped
            logic [ERR_W-1:0]   err_q [HIST_DEPTH];
            logic [PHASE_W-1:0] ext   [HIST_DEPTH];
            logic [PHASE_W-1:0] fb_w;
            logic [PHASE_W-1:0] sum_w;

            for (genvar i = 0; i < HIST_DEPTH; i++) begin : g_ext
                assign ext[i] = {{PAD_W{1'b0}}, err_q[i]};
            end

            // 4*e1 - 6*e2 + 4*e3 - e4, all modulo 2^PHASE_W
            always_comb begin
                fb_w  = (ext[0] << 2) + (ext[2] << 2)
                      - (ext[1] << 2) - (ext[1] << 1) - ext[3];
                sum_w = phase_i + fb_w;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    addr_o <= '0;
                    for (int i = 0; i < HIST_DEPTH; i++) err_q[i] <= '0;
                end else if (step_i) begin
                    addr_o   <= sum_w[PHASE_W-1 -: ADDR_W];
                    err_q[0] <= sum_w[ERR_W-1:0];
                    for (int i = 1; i < HIST_DEPTH; i++) err_q[i] <= err_q[i-1];
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)         addr_o <= '0;
                else if (step_i) addr_o <= phase_i[PHASE_W-1 -: ADDR_W];
            end
        end
    endgenerate

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [AMP_W-1:0]  amp_o,
    output logic              valid_o
);
    import dds_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [AMP_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        localparam int CODE = sine_code(k, ADDR_W, AMP_W);
        assign tbl[k] = CODE[AMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= step_i;
            if (step_i) amp_o <= tbl[addr_i];
        end
    end

endmodule

// File: rtl/dds_nco_core.sv
module dds_nco_core #(
    parameter int PHASE_W  = 16,
    parameter int ADDR_W   = 8,
    parameter int AMP_W    = 12,
    parameter bit SHAPE_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] fcw_i,
    output logic [AMP_W-1:0]   amp_o,
    output logic               valid_o
);

    logic [PHASE_W-1:0] phase_w;
    logic               acc_step;
    logic [ADDR_W-1:0]  addr_w;
    logic               shp_step;

    dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .step_i  (en_i),
        .fcw_i   (fcw_i),
        .phase_o (phase_w),
        .step_o  (acc_step)
    );

    dds_err_shaper #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SHAPE_EN(SHAPE_EN)) u_shp (
        .clk     (clk),
        .rst     (rst),
        .step_i  (acc_step),
        .phase_i (phase_w),
        .addr_o  (addr_w),
        .step_o  (shp_step)
    );

    dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk     (clk),
        .rst     (rst),
        .step_i  (shp_step),
        .addr_i  (addr_w),
        .amp_o   (amp_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/dds_nco_chk.sv
module dds_nco_chk #(
    parameter int PHASE_W = 16,
    parameter int AMP_W   = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               en_i,
    input logic [PHASE_W-1:0] fcw_i,
    input logic [PHASE_W-1:0] phase,
    input logic [AMP_W-1:0]   amp_o,
    input logic               valid_o
);

    logic [1:0] since;

    always_ff @(posedge clk) begin
        if (rst)                since <= 2'd0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd0) |-> (!valid_o && amp_o == '0 && phase == '0));

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (since == 2'd3) |-> (valid_o == $past(en_i, 3)));

    // R3
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (since != 2'd0 && $past(en_i)) |-> (phase == $past(phase) + $past(fcw_i)));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since != 2'd0 && !$past(en_i)) |-> $stable(phase));

    // R5
    amp_range_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (amp_o != {1'b1, {(AMP_W-1){1'b0}}}));

    // R6
    amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since != 2'd0 && !valid_o) |-> $stable(amp_o));

endmodule

bind dds_nco_core dds_nco_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_i    (en_i),
    .fcw_i   (fcw_i),
    .phase   (phase_w),
    .amp_o   (amp_o),
    .valid_o (valid_o)
);

// File: tb/tb_dds_nco_core.sv
module tb_dds_nco_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] fcw = '0;
    logic [11:0] amp_sh;
    logic [11:0] amp_by;
    logic        vld_sh;
    logic        vld_by;

    int n_chk  = 0;
    int n_fail = 0;
    bit checking = 1'b0;
    string tag_sh = "R4";
    string tag_by = "R7";

    always #4 clk = ~clk;

    dds_nco_core dut (
        .clk(clk), .rst(rst), .en_i(en), .fcw_i(fcw),
        .amp_o(amp_sh), .valid_o(vld_sh)
    );

    dds_nco_core #(.SHAPE_EN(1'b0)) dut_bypass (
        .clk(clk), .rst(rst), .en_i(en), .fcw_i(fcw),
        .amp_o(amp_by), .valid_o(vld_by)
    );

    function automatic int ref_amp(int a);
        real v;
        v = 2047.0 * $sin(2.0 * 3.14159265358979 * real'(a) / 256.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(0.5 - v);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: three-sample delay line plus phase and error history
    int  m_acc;
    int  m_err[$];
    bit  p1_v, p2_v, o_v;
    int  p1_sh, p1_by, p2_sh, p2_by;
    int  o_sh, o_by;

    always @(posedge clk) begin
        if (rst) begin
            m_acc = 0;
            m_err = '{0, 0, 0, 0};
            p1_v = 0; p2_v = 0; o_v = 0;
            p1_sh = 0; p1_by = 0; p2_sh = 0; p2_by = 0;
            o_sh = 0; o_by = 0;
        end else begin
            int y;
            o_v = p2_v;
            if (p2_v) begin
                o_sh = ref_amp(p2_sh);
                o_by = ref_amp(p2_by);
            end
            p2_v = p1_v; p2_sh = p1_sh; p2_by = p1_by;
            p1_v = en;
            if (en) begin
                m_acc = (m_acc + int'(fcw)) % 65536;
                y = m_acc + 4 * m_err[0] - 6 * m_err[1] + 4 * m_err[2] - m_err[3];
                y = ((y % 65536) + 65536) % 65536;
                p1_sh = y / 256;
                p1_by = m_acc / 256;
                m_err.push_front(y % 256);
                void'(m_err.pop_back());
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            check("R2", "valid shaped", int'(vld_sh), int'(o_v));
            check("R2", "valid bypass", int'(vld_by), int'(o_v));
            check(o_v ? tag_sh : "R6", "amp shaped", int'($signed(amp_sh)), o_sh);
            check(o_v ? tag_by : "R6", "amp bypass", int'($signed(amp_by)), o_by);
        end
    end

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; fcw = '0;
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: cleared outputs after reset on both variants
        check("R1", "reset amp shaped", int'(amp_sh), 0);
        check("R1", "reset valid shaped", int'(vld_sh), 0);
        check("R1", "reset amp bypass", int'(amp_by), 0);
        check("R1", "reset valid bypass", int'(vld_by), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int sum_a;
        int hits;
        @(posedge clk);
        checking = 1'b1;
        do_reset();

        // R4 R7: slow sweep, one address per sample
        tag_sh = "R4"; tag_by = "R7";
        en = 1'b1; fcw = 16'h0100;
        cycles(40);

        // R5: quarter-turn steps on the bypass variant give 2047, 0, -2047, 0
        tag_by = "R5";
        do_reset();
        en = 1'b1; fcw = 16'h4000;
        cycles(3);
        check("R5", "quarter amp", int'($signed(amp_by)), 2047);
        @(negedge clk);
        check("R5", "half amp", int'($signed(amp_by)), 0);
        @(negedge clk);
        check("R5", "three-quarter amp", int'($signed(amp_by)), -2047);
        cycles(5);
        tag_by = "R7";

        // R3: gapped enable pattern with an odd step
        tag_sh = "R3";
        fcw = 16'h0731;
        for (int i = 0; i < 60; i++) begin
            en = (i % 3) != 0;
            @(negedge clk);
        end
        en = 1'b0;
        cycles(6);

        // R4: changing step words including a negative-looking one
        tag_sh = "R4";
        en = 1'b1;
        fcw = 16'hFFFF;
        cycles(20);
        for (int i = 0; i < 200; i++) begin
            fcw = 16'((i * 40503 + 17) & 16'hFFFF);
            @(negedge clk);
        end

        // R8: freeze the phase at 0x1280 and average the dithered addresses
        do_reset();
        tag_sh = "R8"; tag_by = "R7";
        en = 1'b1; fcw = 16'h1280;
        @(negedge clk);
        fcw = 16'h0000;
        cycles(10);
        check("R7", "frozen bypass amp", int'($signed(amp_by)), ref_amp(18));
        sum_a = 0;
        for (int i = 0; i < 256; i++) begin
            hits = -1;
            for (int a = 0; a < 64; a++)
                if (ref_amp(a) == int'($signed(amp_sh))) hits = a;
            sum_a += hits;
            @(negedge clk);
        end
        n_chk++;
        if (2 * sum_a - 37 * 256 > 512 || 37 * 256 - 2 * sum_a > 512) begin
            n_fail++;
            $display("FAIL R8 mean address x2: actual %0d expected %0d", 2 * sum_a, 37 * 256);
        end

        en = 1'b0;
        cycles(4);
        checking = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule